// File: doc/BRIEF.md
# Frame schedule list walker

The walker is the bus-master sequencer of a host controller's periodic and asynchronous schedule. While the run control is high it starts one frame per frame tick. A new frame also starts at once when run control rises. For each frame it reads one entry from a frame list in memory. It then follows a linked structure of queue heads and transfer descriptors, using a single 32-bit memory port that allows one access in flight. Each descriptor it reaches is fetched in full and offered to a completion unit over a valid/ready handshake. The completion unit answers with a verdict, an updated control word and interrupt causes. The walker writes a changed control word back into the descriptor. When a queue-head element completes, the walker advances the queue head's element pointer in memory.

At frame end the walker steps an 11-bit frame number and pulses a done strobe. It also presents the OR of all interrupt causes gathered during the frame, with a separate strobe when that OR is non-zero. A visit budget bounds the work done in one frame, so a looping schedule cannot stall the controller.

Top module: `sched_walker`

## Requirements
- R1: After reset the frame number is 0 and there is no memory request, no descriptor offer, no done strobe and no busy indication.
- R2: A frame starts in the cycle after `run_i` is seen rising, or after `frame_tick_i` is seen while `run_i` is high and the walker is idle. A tick while `run_i` is low, and a tick or run edge while a frame is in progress, are ignored.
- R3: The frame-list entry is read at `list_base_i + 4*frnum[9:0]`. When a frame ends, `frame_done_o` pulses for one cycle and the frame number advances by one, modulo 2048.
- R4: In a link pointer, bit 0 set means end of list and bit 1 set means queue head (clear means descriptor). Bit 2 set requests depth-first handling. The target address is the pointer with bits 3:0 cleared.
- R5: A descriptor is read as four words at offsets 0, 4, 8 and 12: link, control, token and buffer. It is then offered with `td_valid_o` held, with its address stable, until `td_ready_i`. A descriptor reached directly from a link continues the walk at its own link word.
- R6: Verdict encoding on `td_verdict_i`: 0 success, 1 not done, 2 fatal, 3 treated as not done. The returned control word is written to descriptor offset 4 only when it differs from the word read.
- R7: A queue head is two words: the horizontal link at offset 0 and the element link at offset 4. An element link with bit 0 set makes the walk continue at the horizontal link. An element link with bit 1 set makes the walk continue at the element link.
- R8: When a queue-head element descriptor succeeds, its link word is written to queue-head offset 4. If that word has bit 2 set, the new element is handled at once; otherwise the walk continues at the horizontal link. A non-success verdict leaves the queue head unwritten and continues at the horizontal link.
- R9: A fatal verdict ends the frame immediately; the frame number still advances.
- R10: A budget of 100 is decremented for every non-terminating link visited and for every queue-head element descriptor taken. The walk ends at the visit that would bring it to zero, so a descriptor that links to itself is offered 99 times.
- R11: `cause_o` holds the OR of `td_cause_i` over all descriptors of the frame. `int_set_o` pulses with `frame_done_o` only when that OR is non-zero.
- R12: A memory request stays asserted with a stable address until `mem_ready_i`. A read completes on `mem_rvalid_i`, a write completes on acceptance, and no new request is made while a read is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Run control level |
| frame_tick_i | input | 1 | Frame period strobe |
| list_base_i | input | 32 | Frame list base address |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 32 | Byte address of the word |
| mem_wdata_o | output | 32 | Write data |
| mem_ready_i | input | 1 | Request accepted |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| td_valid_o | output | 1 | Descriptor offered |
| td_addr_o | output | 32 | Descriptor address |
| td_ctrl_o | output | 32 | Descriptor control word |
| td_token_o | output | 32 | Descriptor token word |
| td_buf_o | output | 32 | Descriptor buffer word |
| td_ready_i | input | 1 | Completion unit accepts the descriptor, result valid |
| td_verdict_i | input | 2 | Completion verdict |
| td_ctrl_i | input | 32 | Updated control word |
| td_cause_i | input | 2 | Interrupt causes raised by this descriptor |
| frame_done_o | output | 1 | Frame finished strobe |
| int_set_o | output | 1 | Frame finished with causes |
| cause_o | output | 2 | Causes gathered in the last frame |
| frnum_o | output | 11 | Frame number |
| busy_o | output | 1 | Frame in progress |

## Verification
Two things can meet in one cycle: the end of a frame and the arrival of the next frame tick. The bench raises a tick in the exact cycle in which it sees `frame_done_o`, and a new frame must start. It also raises a tick while a long, budget-bound frame is still walking, and that tick must be lost: the frame number may advance only once and the walker must fall idle. The element-pointer write-back and the depth-first re-entry also meet in a single step. Schedules where the written link chains onward and where it terminates are both compared against a behavioural walk of a shadow memory.

// File: rtl/sw_pkg.sv
package sw_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_ENTRY, S_LINK, S_QH_RD, S_QH_EVAL,
    S_TD_RD, S_OFFER, S_TD_WB, S_POST, S_QH_WB, S_END
  } walk_state_e;

  typedef enum logic [1:0] {
    V_OK = 2'd0, V_RETRY = 2'd1, V_FATAL = 2'd2, V_RSVD = 2'd3
  } verdict_e;

  localparam int unsigned LNK_TERM  = 0;
  localparam int unsigned LNK_QH    = 1;
  localparam int unsigned LNK_DEPTH = 2;

  function automatic logic [31:0] ptr_addr(input logic [31:0] p);
    return {p[31:4], 4'b0000};
  endfunction
endpackage

// File: rtl/sw_frame_ctr.sv
module sw_frame_ctr #(
  parameter int unsigned FN_W  = 11,
  parameter int unsigned IDX_W = 10,
  parameter int unsigned AW    = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            step_i,
  input  logic [AW-1:0]   base_i,
  output logic [FN_W-1:0] frnum_o,
  output logic [AW-1:0]   entry_addr_o
);
  logic [FN_W-1:0] fn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     fn_q <= '0;
    else if (step_i) fn_q <= fn_q + 1'b1;
  end

  assign frnum_o      = fn_q;
  assign entry_addr_o = base_i + (AW'(fn_q[IDX_W-1:0]) << 2);

  p_fn_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> fn_q == FN_W'($past(fn_q) + 1'b1));
  p_fn_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(fn_q));
endmodule

// File: rtl/sw_visit_budget.sv
module sw_visit_budget #(
  parameter int unsigned MAX_VISITS = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic dec_i,
  output logic last_o
);
  localparam int unsigned CW = $clog2(MAX_VISITS + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= CW'(MAX_VISITS);
    else if (load_i) cnt_q <= CW'(MAX_VISITS);
    else if (dec_i)  cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == CW'(1));

  p_no_underflow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> cnt_q > CW'(1));
  p_reload_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == CW'(MAX_VISITS));
endmodule

// File: rtl/sched_walker.sv
module sched_walker
  import sw_pkg::*;
#(
  parameter int unsigned FN_W       = 11,
  parameter int unsigned IDX_W      = 10,
  parameter int unsigned MAX_VISITS = 100,
  parameter int unsigned CAUSE_W    = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic               frame_tick_i,
  input  logic [31:0]        list_base_i,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [31:0]        mem_addr_o,
  output logic [31:0]        mem_wdata_o,
  input  logic               mem_ready_i,
  input  logic               mem_rvalid_i,
  input  logic [31:0]        mem_rdata_i,
  output logic               td_valid_o,
  output logic [31:0]        td_addr_o,
  output logic [31:0]        td_ctrl_o,
  output logic [31:0]        td_token_o,
  output logic [31:0]        td_buf_o,
  input  logic               td_ready_i,
  input  logic [1:0]         td_verdict_i,
  input  logic [31:0]        td_ctrl_i,
  input  logic [CAUSE_W-1:0] td_cause_i,
  output logic               frame_done_o,
  output logic               int_set_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [FN_W-1:0]    frnum_o,
  output logic               busy_o
);
  walk_state_e        st_q;
  verdict_e           verd_q;
  logic               run_q, wait_q, in_qh_q, done_q, int_q;
  logic [1:0]         idx_q;
  logic [31:0]        link_q, qh_q, horiz_q, elem_q, td_q, nctrl_q;
  logic [3:0][31:0]   tdw_q;
  logic [CAUSE_W-1:0] cause_q;
  logic [31:0]        entry_addr;
  logic               start, last, dec_c, acc, rd_done;

  assign start   = (st_q == S_IDLE) && run_i && (!run_q || frame_tick_i);
  assign acc     = mem_req_o && mem_ready_i;
  assign rd_done = wait_q && mem_rvalid_i;

  sw_frame_ctr #(.FN_W(FN_W), .IDX_W(IDX_W), .AW(32)) u_fctr (
    .clk_i, .rst_ni, .step_i(st_q == S_END), .base_i(list_base_i),
    .frnum_o, .entry_addr_o(entry_addr));

  sw_visit_budget #(.MAX_VISITS(MAX_VISITS)) u_budget (
    .clk_i, .rst_ni, .load_i(start), .dec_i(dec_c), .last_o(last));

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    dec_c       = 1'b0;
    unique case (st_q)
      S_ENTRY:   begin mem_req_o = !wait_q; mem_addr_o = entry_addr; end
      S_QH_RD:   begin mem_req_o = !wait_q; mem_addr_o = qh_q + (32'(idx_q) << 2); end
      S_TD_RD:   begin mem_req_o = !wait_q; mem_addr_o = td_q + (32'(idx_q) << 2); end
      S_TD_WB:   begin
        mem_req_o = 1'b1; mem_we_o = 1'b1;
        mem_addr_o = td_q + 32'd4; mem_wdata_o = nctrl_q;
      end
      S_QH_WB:   begin
        mem_req_o = 1'b1; mem_we_o = 1'b1;
        mem_addr_o = qh_q + 32'd4; mem_wdata_o = tdw_q[0];
      end
      S_LINK:    dec_c = !link_q[LNK_TERM] && !last;
      S_QH_EVAL: dec_c = !elem_q[LNK_TERM] && !elem_q[LNK_QH] && !last;
      default:   ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE; verd_q <= V_OK;
      run_q <= 1'b0; wait_q <= 1'b0; in_qh_q <= 1'b0; done_q <= 1'b0; int_q <= 1'b0;
      idx_q <= '0; link_q <= '0; qh_q <= '0; horiz_q <= '0; elem_q <= '0;
      td_q <= '0; nctrl_q <= '0; tdw_q <= '0; cause_q <= '0;
    end else begin
      run_q  <= run_i;
      done_q <= 1'b0;
      int_q  <= 1'b0;
      if (acc && !mem_we_o) wait_q <= 1'b1;
      else if (rd_done)     wait_q <= 1'b0;
      unique case (st_q)
        S_IDLE: if (start) begin st_q <= S_ENTRY; cause_q <= '0; end
        S_ENTRY: if (rd_done) begin link_q <= mem_rdata_i; st_q <= S_LINK; end
        S_LINK: begin
          idx_q <= '0;
          if (link_q[LNK_TERM] || last) st_q <= S_END;
          else if (link_q[LNK_QH]) begin qh_q <= ptr_addr(link_q); st_q <= S_QH_RD; end
          else begin td_q <= ptr_addr(link_q); in_qh_q <= 1'b0; st_q <= S_TD_RD; end
        end
        S_QH_RD: if (rd_done) begin
          if (idx_q == 2'd0) begin horiz_q <= mem_rdata_i; idx_q <= 2'd1; end
          else begin elem_q <= mem_rdata_i; st_q <= S_QH_EVAL; end
        end
        S_QH_EVAL: begin
          idx_q <= '0;
          if (elem_q[LNK_TERM])    begin link_q <= horiz_q; st_q <= S_LINK; end
          else if (elem_q[LNK_QH]) begin link_q <= elem_q;  st_q <= S_LINK; end
          else if (last)           st_q <= S_END;
          else begin td_q <= ptr_addr(elem_q); in_qh_q <= 1'b1; st_q <= S_TD_RD; end
        end
        S_TD_RD: if (rd_done) begin
          tdw_q[idx_q] <= mem_rdata_i;
          idx_q        <= idx_q + 2'd1;
          if (idx_q == 2'd3) st_q <= S_OFFER;
        end
        S_OFFER: if (td_ready_i) begin
          verd_q  <= verdict_e'(td_verdict_i);
          nctrl_q <= td_ctrl_i;
          cause_q <= cause_q | td_cause_i;
          st_q    <= (td_ctrl_i != tdw_q[1]) ? S_TD_WB : S_POST;
        end
        S_TD_WB: if (acc) st_q <= S_POST;
        S_POST: begin
          if (verd_q == V_FATAL) st_q <= S_END;
          else if (in_qh_q && verd_q == V_OK) st_q <= S_QH_WB;
          else begin link_q <= in_qh_q ? horiz_q : tdw_q[0]; st_q <= S_LINK; end
        end
        S_QH_WB: if (acc) begin
          elem_q <= tdw_q[0];
          if (tdw_q[0][LNK_DEPTH]) st_q <= S_QH_EVAL;
          else begin link_q <= horiz_q; st_q <= S_LINK; end
        end
        S_END: begin done_q <= 1'b1; int_q <= |cause_q; st_q <= S_IDLE; end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign td_valid_o   = (st_q == S_OFFER);
  assign td_addr_o    = td_q;
  assign td_ctrl_o    = tdw_q[1];
  assign td_token_o   = tdw_q[2];
  assign td_buf_o     = tdw_q[3];
  assign frame_done_o = done_q;
  assign int_set_o    = int_q;
  assign cause_o      = cause_q;
  assign busy_o       = (st_q != S_IDLE);

  p_req_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));
  p_td_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    td_valid_o && !td_ready_i |=> td_valid_o && $stable(td_addr_o));
  p_start_run_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(run_i));
  p_quiet_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o && !td_valid_o);
  p_int_with_done_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_set_o |-> frame_done_o && (cause_o != '0));
  p_done_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> !busy_o && $past(busy_o));
endmodule

// File: tb/sched_walker_bench.sv
module sched_walker_bench;
  localparam time TCLK = 10ns;
  localparam logic [31:0] BASE = 32'h0001_0000;

  logic clk = 1'b0, rst_ni = 1'b0, run_i = 1'b0, tick_i = 1'b0;
  logic mem_req_o, mem_we_o, mem_ready_i = 1'b0, mem_rvalid_i = 1'b0;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i = '0;
  logic td_valid_o, td_ready_i = 1'b0;
  logic [31:0] td_addr_o, td_ctrl_o, td_token_o, td_buf_o, td_ctrl_i = '0;
  logic [1:0] td_verdict_i = '0, td_cause_i = '0, cause_o;
  logic frame_done_o, int_set_o, busy_o;
  logic [10:0] frnum_o;

  always #(TCLK/2) clk = ~clk;

  sched_walker u_sched_walker (
    .clk_i(clk), .rst_ni, .run_i, .frame_tick_i(tick_i), .list_base_i(BASE),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_ready_i, .mem_rvalid_i, .mem_rdata_i,
    .td_valid_o, .td_addr_o, .td_ctrl_o, .td_token_o, .td_buf_o, .td_ready_i,
    .td_verdict_i, .td_ctrl_i, .td_cause_i, .frame_done_o, .int_set_o, .cause_o,
    .frnum_o, .busy_o);

  int checks = 0, errors = 0;
  logic [31:0] mm [logic [31:0]];
  logic [31:0] mr [logic [31:0]];
  logic [31:0] exp_q [$];
  int   exp_wr, wr_cnt, efn, clk_fn, cyc;
  logic [1:0] exp_cause;
  bit   rd_pend, ran;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic put(input logic [31:0] a, input logic [31:0] v);
    mm[a] = v; mr[a] = v;
  endtask

  function automatic logic [31:0] rdm(input logic [31:0] a);
    return mm.exists(a) ? mm[a] : 32'h1;
  endfunction
  function automatic logic [31:0] rdr(input logic [31:0] a);
    return mr.exists(a) ? mr[a] : 32'h1;
  endfunction

  // completion behaviour: token[1:0] verdict, token[3:2] causes, token[4] keeps ctrl
  task automatic comp(input logic [31:0] c, input logic [31:0] t,
                      output logic [31:0] nc, output logic [1:0] v, output logic [1:0] irq);
    v = t[1:0]; irq = t[3:2]; nc = t[4] ? c : c + 32'd1;
  endtask

  task automatic ref_td(input logic [31:0] a, output logic [1:0] v);
    logic [31:0] c, nc; logic [1:0] irq;
    exp_q.push_back(a);
    c = rdr(a + 4);
    comp(c, rdr(a + 8), nc, v, irq);
    if (nc != c) begin mr[a + 4] = nc; exp_wr++; end
    exp_cause |= irq;
  endtask

  task automatic ref_frame();
    logic [31:0] link, qa, h, e, a; logic [1:0] v; int cnt; bit stop;
    link = rdr(BASE + 32'((efn % 1024) * 4));
    cnt = 100; stop = 0; exp_cause = '0; exp_wr = 0;
    while (!stop && !link[0]) begin
      cnt--;
      if (cnt == 0) break;
      if (link[1]) begin
        qa = link & 32'hFFFF_FFF0; h = rdr(qa); e = rdr(qa + 4);
        forever begin
          if (e[0]) begin link = h; break; end
          if (e[1]) begin link = e; break; end
          cnt--;
          if (cnt == 0) begin stop = 1; break; end
          a = e & 32'hFFFF_FFF0;
          ref_td(a, v);
          if (v == 2'd2) begin stop = 1; break; end
          if (v == 2'd0) begin
            e = rdr(a); mr[qa + 4] = e; exp_wr++;
            if (e[2]) continue;
          end
          link = h; break;
        end
      end else begin
        a = link & 32'hFFFF_FFF0;
        ref_td(a, v);
        if (v == 2'd2) stop = 1; else link = rdr(a);
      end
    end
  endtask

  // memory responder
  initial begin
    logic [31:0] rdat; int rlat;
    rd_pend = 0; rlat = 0; rdat = '0;
    forever begin
      @(negedge clk);
      cyc++;
      if (mem_rvalid_i) mem_rvalid_i = 1'b0;
      if (rd_pend) begin
        if (rlat == 0) begin mem_rvalid_i = 1'b1; mem_rdata_i = rdat; rd_pend = 0; end
        else rlat--;
      end
      if (rst_ni) chk(!(mem_req_o && (rd_pend || mem_rvalid_i)), "R12", "request while read outstanding", 32'(mem_req_o), 0);
      mem_ready_i = (cyc % 3) != 1;
      if (mem_req_o && mem_ready_i) begin
        if (mem_we_o) begin mm[mem_addr_o] = mem_wdata_o; wr_cnt++; end
        else begin rd_pend = 1; rdat = rdm(mem_addr_o); rlat = cyc % 2; end
      end
    end
  end

  // completion unit
  initial begin
    int dly; logic [31:0] nc; logic [1:0] v, irq;
    dly = 1;
    forever begin
      @(negedge clk);
      if (td_ready_i) td_ready_i = 1'b0;
      else if (td_valid_o) begin
        if (dly == 0) begin
          comp(td_ctrl_o, td_token_o, nc, v, irq);
          td_ctrl_i = nc; td_verdict_i = v; td_cause_i = irq; td_ready_i = 1'b1;
          chk(exp_q.size() > 0 && exp_q[0] == td_addr_o, "R5", "descriptor order",
              td_addr_o, exp_q.size() > 0 ? exp_q[0] : 32'hDEAD_BEEF);
          if (exp_q.size() > 0) void'(exp_q.pop_front());
          dly = cyc % 3;
        end else dly--;
      end
    end
  end

  // frame number compared on every clock
  initial begin
    clk_fn = 0;
    forever begin
      @(negedge clk);
      if (rst_ni) begin
        if (frame_done_o) clk_fn = (clk_fn + 1) % 2048;
        chk(frnum_o == 11'(clk_fn), "R3", "frame number", 32'(frnum_o), 32'(clk_fn));
      end
    end
  end

  // trig: 0 tick at next negedge, 1 run rise, 2 tick now, 3 tick plus a stray tick mid-frame
  task automatic run_frame(input int trig, input string req);
    int k;
    bit seen;
    ref_frame();
    wr_cnt = 0;
    if (trig == 0 || trig == 3) @(negedge clk);
    if (trig == 1) run_i = 1'b1; else tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
    chk(busy_o, "R2", "frame started", 32'(busy_o), 1);
    k = 0; seen = 0;
    while (!seen) begin
      @(negedge clk);
      k++;
      tick_i = (trig == 3 && k == 20);
      seen = frame_done_o;
    end
    tick_i = 1'b0;
    chk(exp_q.size() == 0, req, "descriptors left unvisited", 32'(exp_q.size()), 0);
    exp_q.delete();
    chk(cause_o == exp_cause, "R11", "cause", 32'(cause_o), 32'(exp_cause));
    chk(int_set_o == (exp_cause != 0), "R11", "int strobe", 32'(int_set_o), 32'(exp_cause != 0));
    chk(wr_cnt == exp_wr, "R6", "write count", 32'(wr_cnt), 32'(exp_wr));
    begin
      bit same;
      same = (mm.size() == mr.size());
      foreach (mr[a]) if (!mm.exists(a) || mm[a] != mr[a]) same = 0;
      chk(same, req, "memory image", 32'(mm.size()), 32'(mr.size()));
    end
    efn = (efn + 1) % 2048;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    efn = 0; cyc = 0; wr_cnt = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(frnum_o == 0 && !busy_o && !frame_done_o, "R1", "reset state", 32'(frnum_o), 0);
    chk(!mem_req_o && !td_valid_o, "R1", "no traffic in reset", 32'(mem_req_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy_o && !mem_req_o, "R1", "idle after reset", 32'(busy_o), 0);

    // R4 R5 R6: plain chain, one unchanged descriptor
    put(BASE + 0, 32'h2000);
    put(32'h2000, 32'h2010); put(32'h2004, 32'h10); put(32'h2008, 32'h4); put(32'h200C, 32'hA);
    put(32'h2010, 32'h2020); put(32'h2014, 32'h20); put(32'h2018, 32'h11); put(32'h201C, 32'hB);
    put(32'h2020, 32'h1);    put(32'h2024, 32'h30); put(32'h2028, 32'h8); put(32'h202C, 32'hC);
    run_frame(1, "R2");
    // R7 R8: element advances without depth bit, then horizontal
    put(BASE + 4, 32'h3002);
    put(32'h3000, 32'h2100); put(32'h3004, 32'h2110);
    put(32'h2100, 32'h1);    put(32'h2104, 32'h0); put(32'h2108, 32'h0);
    put(32'h2110, 32'h2120); put(32'h2114, 32'h0); put(32'h2118, 32'h4);
    put(32'h2120, 32'h1);    put(32'h2124, 32'h0); put(32'h2128, 32'h0);
    run_frame(0, "R8");
    // R8 depth-first chain to termination
    put(BASE + 8, 32'h3102);
    put(32'h3100, 32'h1); put(32'h3104, 32'h2200);
    put(32'h2200, 32'h2214); put(32'h2204, 32'h0); put(32'h2208, 32'h0);
    put(32'h2210, 32'h2224); put(32'h2214, 32'h0); put(32'h2218, 32'h8);
    put(32'h2220, 32'h1);    put(32'h2224, 32'h5); put(32'h2228, 32'h10);
    run_frame(0, "R8");
    // R7 element is a queue head
    put(BASE + 12, 32'h3202);
    put(32'h3200, 32'h1); put(32'h3204, 32'h3302);
    put(32'h3300, 32'h2300); put(32'h3304, 32'h1);
    put(32'h2300, 32'h1); put(32'h2304, 32'h7); put(32'h2308, 32'h14);
    run_frame(0, "R7");
    // R8 non-success element leaves queue head alone
    put(BASE + 16, 32'h3502);
    put(32'h3500, 32'h2410); put(32'h3504, 32'h2400);
    put(32'h2400, 32'h2420); put(32'h2404, 32'h0); put(32'h2408, 32'h1);
    put(32'h2410, 32'h1);    put(32'h2414, 32'h0); put(32'h2418, 32'h0);
    put(32'h2420, 32'h1);    put(32'h2424, 32'h0); put(32'h2428, 32'h0);
    run_frame(0, "R8");
    // R9 fatal stops the frame
    put(BASE + 20, 32'h2500);
    put(32'h2500, 32'h2510); put(32'h2504, 32'h0); put(32'h2508, 32'h6);
    put(32'h2510, 32'h1);    put(32'h2514, 32'h0); put(32'h2518, 32'h0);
    run_frame(0, "R9");
    // R10 self loop hits the budget; R2 stray tick while busy
    put(BASE + 24, 32'h2600);
    put(32'h2600, 32'h2600); put(32'h2604, 32'h0); put(32'h2608, 32'h15);
    run_frame(3, "R10");
    repeat (6) @(negedge clk);
    chk(!busy_o, "R2", "tick while busy ignored", 32'(busy_o), 0);
    // R2 tick with run low is ignored
    run_i = 1'b0;
    @(negedge clk); tick_i = 1'b1; @(negedge clk); tick_i = 1'b0;
    repeat (8) @(negedge clk);
    chk(!busy_o && frnum_o == 11'(efn), "R2", "tick while stopped", 32'(frnum_o), 32'(efn));
    run_frame(1, "R2");
    // R2 tick in the cycle of frame end starts a new frame
    run_frame(2, "R2");
    // R3 run through the wrap of the frame number
    ran = 0;
    while (!(ran && efn == 3)) begin
      if (efn == 0) ran = 1;
      run_frame(0, "R3");
    end
    chk(frnum_o == 11'd3, "R3", "wrap modulo 2048", 32'(frnum_o), 3);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule